// File: doc/BRIEF.md
# Multi-Class Physical Register Free List

This block keeps the pool of unused physical register tags that a rename stage draws from. There are six register classes, and each has its own queue: integer, floating point, vector, vector element, predicate and condition code. A tag value only has meaning inside its own class, so the same index can sit in two pools at once. The rename stage asks for one tag per cycle by class and gets the oldest free tag of that class back in the same cycle. Retiring instructions return tags through a single-tag release port that steers by class code. They can also use a multi-lane release port that takes up to four tags of one class in a cycle.

The block checks each request. A request for a tag from an empty pool, an undefined class code, a multi-lane release whose lanes name different classes, and a release that would push a pool past its physical size each raise a one-cycle error flag. The offending operation leaves the pools as they were. Each pool exports its free count and a non-empty flag so that rename can stall ahead of time.

Top module: `regfree_list`

## Requirements
- R1: After reset, every pool holds the tags ARCH_REGS up to PHYS_REGS-1, in ascending order. Its free count is PHYS_REGS-ARCH_REGS and its non-empty flag is high. All error flags are low.
- R2: Within a class, tags are handed out first-in first-out. When allocValid is high and the selected pool is not empty, allocGrant is high and allocTag shows the pool's oldest tag in the same cycle. That tag leaves the pool at the next rising edge.
- R3: Class codes are integer=0, floating point=1, vector=2, vector element=3, predicate=4 and condition code=5. A released tag is added only to the pool its code selects. The same index value may be held by two pools at once.
- R4: An allocate aimed at an empty pool gives allocGrant low and leaves that pool's count unchanged. It sets errEmpty high in the cycle after the request edge.
- R5: An allocate, a single release or a multi-lane release that carries class code 6 or 7 changes no pool. It sets errClass high in the cycle after the request edge.
- R6: brstMask bit i enables lane i. The lane's tag is at brstTags[i*TAG_W +: TAG_W] and its class is at brstClass[i*3 +: 3]. The enabled tags are appended in ascending lane order, after any single-release tag to the same class in that cycle. A zero mask changes nothing and raises no error, whatever the other lane fields hold.
- R7: If any enabled lane carries a class different from the lowest enabled lane, none of the lane tags is written. errMixed is high in the cycle after the request edge.
- R8: If the releases to one class in a cycle would take its free count above PHYS_REGS, all of that class's releases in that cycle are dropped. errDouble is high in the cycle after the request edge, and the count never exceeds PHYS_REGS.
- R9: An allocate and a release to the same class in one cycle both take effect, so the count is unchanged; this also holds for a full pool, with no error. If the pool was empty, the allocate fails and the released tag is not forwarded to it, and the count becomes 1.
- R10: freeCnt[c*CNT_W +: CNT_W] and nonEmpty[c] give pool c's count and whether that count is non-zero. Both are updated at the same edge as the pool.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Request one tag |
| allocClass | input | 3 | Class code of the request |
| allocGrant | output | 1 | Request can be served this cycle |
| allocTag | output | TAG_W | Oldest free tag of the requested class |
| relValid | input | 1 | Single-tag release strobe |
| relClass | input | 3 | Class code of the released tag |
| relTag | input | TAG_W | Released tag |
| brstMask | input | LANES | Multi-lane release lane enables |
| brstClass | input | 3*LANES | Per-lane class codes |
| brstTags | input | TAG_W*LANES | Per-lane tags |
| freeCnt | output | 6*CNT_W | Per-class free counts |
| nonEmpty | output | 6 | Per-class count is non-zero |
| errEmpty | output | 1 | Allocate from an empty pool |
| errClass | output | 1 | Undefined class code seen |
| errMixed | output | 1 | Multi-lane release mixed classes |
| errDouble | output | 1 | Release would overflow a pool |

## Verification
allocGrant and allocTag are combinational, so the bench reads them one time unit after it drives a request, before the edge that pops the tag. Counts, non-empty flags and the four error flags are all due one rising edge after the request, with no extra register on the way. The bench reads them one time unit after that edge and returns every input to idle at the same moment. That makes a flag that stays high one cycle too long show up as a mismatch. A queue-per-class model in the bench supplies every expected tag, count and flag.

// File: rtl/flist_pkg.sv
package flist_pkg;
  localparam int NUM_CLS = 6;
  localparam int CLS_W = 3;

  // Per-class strobes issued by the control to the pool datapath.
  typedef struct packed {
    logic [NUM_CLS-1:0] pop;
    logic [NUM_CLS-1:0] pushOne;
    logic [NUM_CLS-1:0] pushMany;
  } poolStrobeT;

  function automatic logic clsDefined(input logic [CLS_W-1:0] code);
    return int'(code) < NUM_CLS;
  endfunction
endpackage

// File: rtl/flist_pool.sv
module flist_pool #(
  parameter int PHYS = 16,
  parameter int ARCH = 8,
  parameter int LANES = 4,
  parameter int TAG_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pop,
  input  logic                   pushOne,
  input  logic                   pushMany,
  input  logic [TAG_W-1:0]       relTag,
  input  logic [LANES-1:0]       laneMask,
  input  logic [LANES*TAG_W-1:0] laneTags,
  output logic [TAG_W-1:0]       headTag,
  output logic [CNT_W-1:0]       count,
  output logic                   emptyHit,
  output logic                   ovf
);
  localparam int PTR_W = (PHYS > 1) ? $clog2(PHYS) : 1;
  localparam int INIT_FREE = PHYS - ARCH;

  logic [TAG_W-1:0] mem [PHYS];
  logic [TAG_W-1:0] memNext [PHYS];
  logic [PTR_W-1:0] headPtr, tailPtr, tailNext;
  logic popOk;
  int   pushReq;
  int   roomNeed;

  function automatic logic [PTR_W-1:0] ptrAdd(input logic [PTR_W-1:0] p, input int k);
    return PTR_W'((int'(p) + k) % PHYS);
  endfunction

  assign popOk    = pop && (count != '0);
  assign emptyHit = pop && (count == '0);
  assign headTag  = mem[headPtr];

  always_comb begin
    pushReq = 0;
    if (pushOne) pushReq = pushReq + 1;
    if (pushMany) pushReq = pushReq + $countones(laneMask);
    roomNeed = int'(count) - (popOk ? 1 : 0) + pushReq;
    ovf = roomNeed > PHYS;
  end

  always_comb begin
    int off;
    off = 0;
    memNext = mem;
    if (!ovf) begin
      if (pushOne) begin
        memNext[ptrAdd(tailPtr, off)] = relTag;
        off = off + 1;
      end
      if (pushMany) begin
        for (int l = 0; l < LANES; l++) begin
          if (laneMask[l]) begin
            memNext[ptrAdd(tailPtr, off)] = laneTags[l*TAG_W +: TAG_W];
            off = off + 1;
          end
        end
      end
    end
    tailNext = ptrAdd(tailPtr, off);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS; i++)
        mem[i] <= (i < INIT_FREE) ? TAG_W'(ARCH + i) : '0;
      headPtr <= '0;
      tailPtr <= PTR_W'(INIT_FREE % PHYS);
      count   <= CNT_W'(INIT_FREE);
    end else begin
      mem     <= memNext;
      tailPtr <= tailNext;
      if (popOk) headPtr <= ptrAdd(headPtr, 1);
      count <= CNT_W'(int'(count) - (popOk ? 1 : 0) + (ovf ? 0 : pushReq));
    end
  end

  // R4: a failed allocate with no release leaves the pool untouched
  a_r4_empty_stable: assert property (@(posedge clk) disable iff (!rstN)
    (pop && count == '0 && !pushOne && !pushMany) |=> (count == '0 && $stable(headPtr)));

  // R8: the count is bounded by the physical size
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= PHYS);

  // R8: a rejected release with no allocate keeps the count
  a_r8_drop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !pop) |=> $stable(count));

  // R9: allocate plus one release on a non-empty pool keeps the count
  a_r9_swap_count: assert property (@(posedge clk) disable iff (!rstN)
    (pop && count != '0 && pushOne && !pushMany) |=> $stable(count));
endmodule

// File: rtl/flist_ctrl.sv
module flist_ctrl
  import flist_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   allocValid,
  input  logic [CLS_W-1:0]       allocClass,
  input  logic                   relValid,
  input  logic [CLS_W-1:0]       relClass,
  input  logic [LANES-1:0]       brstMask,
  input  logic [LANES*CLS_W-1:0] brstClass,
  input  logic [NUM_CLS-1:0]     poolEmptyHit,
  input  logic [NUM_CLS-1:0]     poolOvf,
  output poolStrobeT             strb,
  output logic                   errEmpty,
  output logic                   errClass,
  output logic                   errMixed,
  output logic                   errDouble
);
  logic [CLS_W-1:0] firstCls;
  logic laneSeen, laneMixed, badCode;

  // Class of the lowest enabled lane and whether any other lane disagrees.
  always_comb begin
    firstCls  = '0;
    laneSeen  = 1'b0;
    laneMixed = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (brstMask[l]) begin
        if (!laneSeen) begin
          firstCls = brstClass[l*CLS_W +: CLS_W];
          laneSeen = 1'b1;
        end else if (brstClass[l*CLS_W +: CLS_W] != firstCls) begin
          laneMixed = 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      strb.pop[c]      = allocValid && (allocClass == CLS_W'(c));
      strb.pushOne[c]  = relValid && (relClass == CLS_W'(c));
      strb.pushMany[c] = laneSeen && !laneMixed && (firstCls == CLS_W'(c));
    end
  end

  assign badCode = (allocValid && !clsDefined(allocClass))
                 || (relValid && !clsDefined(relClass))
                 || (laneSeen && !laneMixed && !clsDefined(firstCls));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errEmpty  <= 1'b0;
      errClass  <= 1'b0;
      errMixed  <= 1'b0;
      errDouble <= 1'b0;
    end else begin
      errEmpty  <= |poolEmptyHit;
      errClass  <= badCode;
      errMixed  <= laneSeen && laneMixed;
      errDouble <= |poolOvf;
    end
  end

  // R6: an all-zero lane mask drives no multi-lane push
  a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rstN)
    (brstMask == '0) |-> (strb.pushMany == '0));

  // R4: a pool reporting an empty hit yields the flag one edge later
  a_r4_flag_next: assert property (@(posedge clk) disable iff (!rstN)
    (|poolEmptyHit) |=> errEmpty);

  // R7: a mixed lane set never reaches a pool
  a_r7_no_mixed_push: assert property (@(posedge clk) disable iff (!rstN)
    errMixed |-> ($past(strb.pushMany) == '0));
endmodule

// File: rtl/flist_datapath.sv
module flist_datapath
  import flist_pkg::*;
#(
  parameter int PHYS = 16,
  parameter int ARCH = 8,
  parameter int LANES = 4,
  parameter int TAG_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  poolStrobeT               strb,
  input  logic                     allocValid,
  input  logic [CLS_W-1:0]         allocClass,
  input  logic [TAG_W-1:0]         relTag,
  input  logic [LANES-1:0]         brstMask,
  input  logic [LANES*TAG_W-1:0]   brstTags,
  output logic                     allocGrant,
  output logic [TAG_W-1:0]         allocTag,
  output logic [NUM_CLS*CNT_W-1:0] freeCnt,
  output logic [NUM_CLS-1:0]       nonEmpty,
  output logic [NUM_CLS-1:0]       poolEmptyHit,
  output logic [NUM_CLS-1:0]       poolOvf
);
  logic [TAG_W-1:0] heads [NUM_CLS];
  logic [CNT_W-1:0] counts [NUM_CLS];

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_pool
    flist_pool #(
      .PHYS(PHYS), .ARCH(ARCH), .LANES(LANES), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_pool (
      .clk(clk),
      .rstN(rstN),
      .pop(strb.pop[c]),
      .pushOne(strb.pushOne[c]),
      .pushMany(strb.pushMany[c]),
      .relTag(relTag),
      .laneMask(brstMask),
      .laneTags(brstTags),
      .headTag(heads[c]),
      .count(counts[c]),
      .emptyHit(poolEmptyHit[c]),
      .ovf(poolOvf[c])
    );
    assign freeCnt[c*CNT_W +: CNT_W] = counts[c];
    assign nonEmpty[c] = counts[c] != '0;
  end

  always_comb begin
    allocGrant = 1'b0;
    allocTag   = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (allocClass == CLS_W'(c)) begin
        allocTag   = heads[c];
        allocGrant = allocValid && nonEmpty[c];
      end
    end
  end

  // R2: a grant is only given for a pool holding at least one tag
  a_r2_grant_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> (nonEmpty != '0));
endmodule

// File: rtl/regfree_list.sv
module regfree_list
  import flist_pkg::*;
#(
  parameter int PHYS_REGS = 16,
  parameter int ARCH_REGS = 8,
  parameter int LANES = 4,
  localparam int TAG_W = (PHYS_REGS > 1) ? $clog2(PHYS_REGS) : 1,
  localparam int CNT_W = $clog2(PHYS_REGS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     allocValid,
  input  logic [CLS_W-1:0]         allocClass,
  output logic                     allocGrant,
  output logic [TAG_W-1:0]         allocTag,
  input  logic                     relValid,
  input  logic [CLS_W-1:0]         relClass,
  input  logic [TAG_W-1:0]         relTag,
  input  logic [LANES-1:0]         brstMask,
  input  logic [LANES*CLS_W-1:0]   brstClass,
  input  logic [LANES*TAG_W-1:0]   brstTags,
  output logic [NUM_CLS*CNT_W-1:0] freeCnt,
  output logic [NUM_CLS-1:0]       nonEmpty,
  output logic                     errEmpty,
  output logic                     errClass,
  output logic                     errMixed,
  output logic                     errDouble
);
  poolStrobeT strb;
  logic [NUM_CLS-1:0] poolEmptyHit, poolOvf;

  flist_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocClass(allocClass),
    .relValid(relValid), .relClass(relClass),
    .brstMask(brstMask), .brstClass(brstClass),
    .poolEmptyHit(poolEmptyHit), .poolOvf(poolOvf),
    .strb(strb),
    .errEmpty(errEmpty), .errClass(errClass),
    .errMixed(errMixed), .errDouble(errDouble)
  );

  flist_datapath #(
    .PHYS(PHYS_REGS), .ARCH(ARCH_REGS), .LANES(LANES), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocValid(allocValid), .allocClass(allocClass),
    .relTag(relTag), .brstMask(brstMask), .brstTags(brstTags),
    .allocGrant(allocGrant), .allocTag(allocTag),
    .freeCnt(freeCnt), .nonEmpty(nonEmpty),
    .poolEmptyHit(poolEmptyHit), .poolOvf(poolOvf)
  );
endmodule

// File: tb/regfree_list_bench.sv
module regfree_list_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PHYS = 16;
  localparam int ARCH = 8;
  localparam int LANES = 4;
  localparam int TAG_W = 4;
  localparam int CNT_W = 5;
  localparam int NCLS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0;
  logic [2:0] allocClass = '0;
  logic allocGrant;
  logic [TAG_W-1:0] allocTag;
  logic relValid = 1'b0;
  logic [2:0] relClass = '0;
  logic [TAG_W-1:0] relTag = '0;
  logic [LANES-1:0] brstMask = '0;
  logic [LANES*3-1:0] brstClass = '0;
  logic [LANES*TAG_W-1:0] brstTags = '0;
  logic [NCLS*CNT_W-1:0] freeCnt;
  logic [NCLS-1:0] nonEmpty;
  logic errEmpty, errClass, errMixed, errDouble;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int pool [NCLS][$];

  always #(CLK_PERIOD/2) clk = ~clk;

  regfree_list u_regfree_list (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocClass(allocClass),
    .allocGrant(allocGrant), .allocTag(allocTag),
    .relValid(relValid), .relClass(relClass), .relTag(relTag),
    .brstMask(brstMask), .brstClass(brstClass), .brstTags(brstTags),
    .freeCnt(freeCnt), .nonEmpty(nonEmpty),
    .errEmpty(errEmpty), .errClass(errClass),
    .errMixed(errMixed), .errDouble(errDouble)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkPools(string req);
    for (int c = 0; c < NCLS; c++) begin
      check(req, $sformatf("count[%0d]", c), int'(freeCnt[c*CNT_W +: CNT_W]), pool[c].size());
      check(req, $sformatf("nonEmpty[%0d]", c), int'(nonEmpty[c]), int'(pool[c].size() > 0));
    end
  endtask

  function automatic logic [11:0] cls4(int a, int b, int c, int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  function automatic logic [15:0] tag4(int a, int b, int c, int d);
    return {4'(d), 4'(c), 4'(b), 4'(a)};
  endfunction

  // One request cycle: drive, check the combinational grant, update the model,
  // cross the edge, then check flags and counts.
  task automatic cyc(string req, bit aV, int aC, bit rV, int rC, int rT,
                     logic [3:0] m, logic [11:0] bc, logic [15:0] bt);
    bit expGrant, eEmpty, eClass, eMixed, eDouble, seen, mixed, burstOk;
    int first;
    allocValid = aV; allocClass = 3'(aC);
    relValid = rV; relClass = 3'(rC); relTag = 4'(rT);
    brstMask = m; brstClass = bc; brstTags = bt;
    #1;
    expGrant = aV && aC < NCLS && pool[aC].size() > 0;
    check(req, "allocGrant", int'(allocGrant), int'(expGrant));
    if (expGrant) check(req, "allocTag", int'(allocTag), pool[aC][0]);
    seen = 0; mixed = 0; first = 0;
    for (int l = 0; l < LANES; l++) begin
      if (m[l]) begin
        if (!seen) begin first = int'(bc[l*3 +: 3]); seen = 1; end
        else if (int'(bc[l*3 +: 3]) != first) mixed = 1;
      end
    end
    burstOk = seen && !mixed && first < NCLS;
    eMixed = seen && mixed;
    eClass = (aV && aC >= NCLS) || (rV && rC >= NCLS) || (seen && !mixed && first >= NCLS);
    eEmpty = aV && aC < NCLS && pool[aC].size() == 0;
    eDouble = 0;
    for (int c = 0; c < NCLS; c++) begin
      int pushes[$];
      int popOk;
      popOk = (aV && aC == c && pool[c].size() > 0) ? 1 : 0;
      if (rV && rC == c) pushes.push_back(rT);
      if (burstOk && first == c)
        for (int l = 0; l < LANES; l++) if (m[l]) pushes.push_back(int'(bt[l*4 +: 4]));
      if (pool[c].size() - popOk + pushes.size() > PHYS) begin
        eDouble = 1;
        pushes.delete();
      end
      if (popOk == 1) void'(pool[c].pop_front());
      foreach (pushes[k]) pool[c].push_back(pushes[k]);
    end
    @(posedge clk);
    #1;
    allocValid = 0; relValid = 0; brstMask = '0;
    check(req, "errEmpty", int'(errEmpty), int'(eEmpty));
    check(req, "errClass", int'(errClass), int'(eClass));
    check(req, "errMixed", int'(errMixed), int'(eMixed));
    check(req, "errDouble", int'(errDouble), int'(eDouble));
    checkPools(req);
  endtask

  task automatic alloc(string req, int c);
    cyc(req, 1, c, 0, 0, 0, '0, '0, '0);
  endtask

  task automatic release1(string req, int c, int t);
    cyc(req, 0, 0, 1, c, t, '0, '0, '0);
  endtask

  task automatic burst(string req, logic [3:0] m, logic [11:0] bc, logic [15:0] bt);
    cyc(req, 0, 0, 0, 0, 0, m, bc, bt);
  endtask

  task automatic t_reset();
    check("R1", "errEmpty", int'(errEmpty), 0);
    check("R1", "errClass", int'(errClass), 0);
    check("R1", "errMixed", int'(errMixed), 0);
    check("R1", "errDouble", int'(errDouble), 0);
    checkPools("R1");
    // first tag of the floating point pool is the lowest free one
    cyc("R1", 1, 1, 0, 0, 0, '0, '0, '0);
  endtask

  task automatic t_fifo();
    for (int i = 0; i < PHYS - ARCH; i++) alloc("R2", 0);
    alloc("R4", 0);
    release1("R2", 0, 5);
    release1("R2", 0, 3);
    alloc("R2", 0);
    alloc("R2", 0);
  endtask

  task automatic t_steer();
    release1("R3", 1, 2);
    release1("R3", 5, 2);
    for (int i = 0; i < PHYS - ARCH + 1; i++) alloc("R3", 5);
    alloc("R10", 5);
  endtask

  task automatic t_badcls();
    release1("R5", 6, 1);
    alloc("R5", 7);
    burst("R5", 4'b0011, cls4(7, 7, 0, 0), tag4(1, 2, 0, 0));
  endtask

  task automatic t_burst();
    cyc("R6", 0, 0, 1, 2, 7, 4'b1011, cls4(2, 2, 4, 2), tag4(1, 2, 9, 3));
    for (int i = 0; i < PHYS - ARCH + 4; i++) alloc("R6", 2);
    burst("R6", 4'b0000, cls4(1, 6, 3, 7), tag4(4, 5, 6, 7));
  endtask

  task automatic t_mixed();
    burst("R7", 4'b1111, cls4(3, 3, 4, 3), tag4(0, 1, 2, 3));
    burst("R7", 4'b1001, cls4(3, 3, 3, 4), tag4(0, 1, 2, 3));
    burst("R7", 4'b0110, cls4(1, 3, 3, 1), tag4(0, 4, 5, 0));
  endtask

  task automatic t_overflow();
    burst("R8", 4'b1111, cls4(4, 4, 4, 4), tag4(0, 1, 2, 3));
    burst("R8", 4'b1111, cls4(4, 4, 4, 4), tag4(4, 5, 6, 7));
    release1("R8", 4, 9);
    cyc("R8", 0, 0, 1, 4, 1, 4'b0011, cls4(4, 4, 0, 0), tag4(2, 3, 0, 0));
    cyc("R9", 1, 4, 1, 4, 12, '0, '0, '0);
    // count 15 after one allocate: single plus two lanes overflows, all dropped
    alloc("R8", 4);
    cyc("R8", 0, 0, 1, 4, 1, 4'b0011, cls4(4, 4, 0, 0), tag4(2, 3, 0, 0));
  endtask

  task automatic t_simul_empty();
    cyc("R9", 1, 0, 1, 0, 9, '0, '0, '0);
    alloc("R9", 0);
    cyc("R9", 1, 3, 0, 0, 0, 4'b0001, cls4(3, 0, 0, 0), tag4(6, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    for (int c = 0; c < NCLS; c++)
      for (int t = ARCH; t < PHYS; t++) pool[c].push_back(t);
    @(posedge clk);
    #1;
    t_reset();
    t_fifo();
    t_steer();
    t_badcls();
    t_burst();
    t_mixed();
    t_overflow();
    t_simul_empty();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule